// File: doc/BRIEF.md
# Multichannel Audio Sample FIFO

This block is the sample buffer that sits between a CPU-side register interface and the serial side of one port and one direction of an audio serial interface. In playback the CPU writes samples and the serial side drains them. In capture the serial side fills the buffer and the CPU reads it out. A single direction input selects which side pushes and which side pops. Only the low 24 bits of a sample are stored. Software places 16-bit samples in bits 23:8.

The usable storage depends on two settings: a size code that scales the base capacity, and the number of interleaved channels. The channel count is rounded up to a power of two before it divides the capacity, so odd channel counts leave part of the RAM idle. A status word gives the fill level in frames, plus two sticky flags: one for pushes that were lost on a full buffer and one for pops made from an empty buffer. When enabled, a level request line tells the CPU that there is room for a refill or data ready to collect. A control write can empty the buffer at once.

Top module: `audio_sample_fifo`

## Requirements
- R1: The capacity in words is BASE_WORDS shifted left by min(cfg_size_code, MAX_CODE). The channel count is clamped to 1..8 (0 acts as 1, above 8 acts as 8). The depth per channel is the capacity shifted right by ceil(log2(channels)). The buffer is full when it holds depth-per-channel times channels words.
- R2: status bits 16:8 give the fill level as a 9-bit frame count, equal to floor(words held / channels). All other status bits except 4 and 0 read as zero.
- R3: In playback (cfg_playback=1), cpu_wr pushes cpu_wdata[23:0]. Bits 31:24 are discarded. ser_req pops the oldest word, which appears on ser_rdata in the cycle after the pop. cpu_rd has no effect.
- R4: In capture (cfg_playback=0), ser_req pushes ser_wdata. cpu_rd pops the oldest word, which appears on cpu_rdata in the cycle after the read. cpu_wr has no effect.
- R5: A push while the buffer is full is dropped and sets status bit 4 (lost push). The stored contents and the fill level do not change.
- R6: A pop while the buffer is empty puts zero on the read data output and sets status bit 0 (empty pop). The fill level stays 0.
- R7: Both flags stay set until a status write. A status write clears each flag whose bit in st_wdata is 0 and keeps each flag whose bit is 1. A flag event in the same cycle as the write wins over the write.
- R8: A control write with ctl_wdata bit 0 set empties the buffer by the next cycle. Any push or pop in the same cycle is discarded and raises no flag. The flags keep their values.
- R9: Control bit 20 is latched on every control write. While bit 20 is 1, half_irq is high whenever 2*words ≤ full depth (playback) or 2*words ≥ full depth (capture). While bit 20 is 0, half_irq is low. After reset, bit 20 is 0.
- R10: A push and a pop in the same cycle both take effect and leave the fill level unchanged. The full and empty tests use the level from before that cycle, so a push into a full buffer is dropped even when a pop happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_playback | input | 1 | 1 = playback (CPU pushes), 0 = capture (serial pushes) |
| cfg_chan | input | 4 | Interleaved channel count |
| cfg_size_code | input | 3 | Capacity scale code |
| cpu_wr | input | 1 | CPU sample write strobe |
| cpu_wdata | input | 32 | CPU sample write data |
| cpu_rd | input | 1 | CPU sample read strobe |
| cpu_rdata | output | 24 | CPU sample read data |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control data: bit 20 request enable, bit 0 empty |
| st_wr | input | 1 | Status register write strobe |
| st_wdata | input | 32 | Status write data: bit 4 / bit 0 keep masks |
| status | output | 24 | Frame level [16:8], lost push [4], empty pop [0] |
| ser_req | input | 1 | Serial-side pop (playback) or push (capture) strobe |
| ser_wdata | input | 24 | Serial-side capture sample |
| ser_rdata | output | 24 | Serial-side playback sample |
| half_irq | output | 1 | Half-level request |

## Verification
On every cycle, the assertions check the following:
- The fill level never goes past the configured depth.
- A dropped push never raises the level.
- An empty pop drives zero.
- A clear leaves the buffer empty.
- The flags stay set between status writes.
- The reported frame count times the channel count never exceeds the depth.

The bench scenarios are the only way to show two things. First, the depth produced by each size code and channel count is the exact one, with the full point landing on exactly the right write. Second, the words come out in arrival order with dropped samples truly absent. The level request thresholds and the same-cycle push and pop rules also need the sequences in the bench.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

  localparam int unsigned DATA_W       = 24;
  localparam int unsigned LVL_LSB      = 8;
  localparam int unsigned LVL_W        = 9;
  localparam int unsigned OVR_BIT      = 4;
  localparam int unsigned UDR_BIT      = 0;
  localparam int unsigned CTL_HALF_BIT = 20;
  localparam int unsigned CTL_CLR_BIT  = 0;

  typedef enum logic {DIR_CAPTURE = 1'b0, DIR_PLAYBACK = 1'b1} dir_e;

  // Channel count limited to the supported 1..8 range.
  function automatic logic [3:0] chan_clamp(input logic [3:0] c);
    if (c == 4'd0) return 4'd1;
    if (c > 4'd8)  return 4'd8;
    return c;
  endfunction

  // Number of halvings of the capacity: ceil(log2(clamped channels)).
  function automatic logic [1:0] chan_shift(input logic [3:0] c);
    logic [3:0] cc;
    cc = chan_clamp(c);
    if (cc == 4'd1) return 2'd0;
    if (cc == 4'd2) return 2'd1;
    if (cc <= 4'd4) return 2'd2;
    return 2'd3;
  endfunction

  // Frames held for a given word count.
  function automatic logic [15:0] frames_of(input logic [15:0] words, input logic [3:0] c);
    return words / {12'd0, chan_clamp(c)};
  endfunction

endpackage

// File: rtl/afifo_geometry.sv
module afifo_geometry #(
  parameter int unsigned BASE_WORDS = 256,
  parameter int unsigned MAX_CODE   = 0,
  parameter int unsigned CW         = 9
) (
  input  logic [2:0]    size_code,
  input  logic [3:0]    chan,
  output logic [3:0]    chan_eff,
  output logic [CW-1:0] total_words
);
  import afifo_pkg::*;

  localparam int unsigned GW = CW + 4;

  logic [2:0]    code_eff;
  logic [GW-1:0] cap_words;
  logic [GW-1:0] per_chan;
  logic [GW-1:0] product;

  always_comb begin
    code_eff    = (size_code > 3'(MAX_CODE)) ? 3'(MAX_CODE) : size_code;
    chan_eff    = chan_clamp(chan);
    cap_words   = GW'(BASE_WORDS) << code_eff;
    per_chan    = cap_words >> chan_shift(chan);
    product     = per_chan * GW'(chan_eff);
    total_words = product[CW-1:0];
  end

endmodule

// File: rtl/afifo_store.sv
module afifo_store #(
  parameter int unsigned RAM_WORDS = 256,
  parameter int unsigned AW        = 8,
  parameter int unsigned CW        = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [23:0]   wdata,
  input  logic [CW-1:0] total_words,
  output logic [23:0]   rdata,
  output logic [CW-1:0] count,
  output logic          push_drop,
  output logic          pop_empty
);

  logic [23:0]   mem [RAM_WORDS];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;
  logic          full_now, empty_now;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p, input logic [CW-1:0] lim);
    if (CW'(p) == lim - CW'(1)) return '0;
    return p + AW'(1);
  endfunction

  assign full_now  = (count >= total_words);
  assign empty_now = (count == '0);
  assign push_ok   = push & ~clr & ~full_now;
  assign pop_ok    = pop  & ~clr & ~empty_now;
  assign push_drop = push & ~clr & full_now;
  assign pop_empty = pop  & ~clr & empty_now;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      rdata  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      if (pop) rdata <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr, total_words);
      if (pop_ok) begin
        rd_ptr <= bump(rd_ptr, total_words);
        rdata  <= mem[rd_ptr];
      end else if (pop) begin
        rdata  <= '0;
      end
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R1: level never exceeds configured depth
  assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= total_words);
  // R5: dropped push never raises the level
  assert_drop_keeps_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> count <= $past(count));
  // R6: empty pop yields zero data
  assert_empty_pop_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_empty |=> rdata == '0);
  // R8: clear leaves the buffer empty
  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);

endmodule

// File: rtl/afifo_flags.sv
module afifo_flags #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_ovr,
  input  logic          set_udr,
  input  logic          st_wr,
  input  logic          keep_ovr,
  input  logic          keep_udr,
  input  logic          ctl_wr,
  input  logic          ctl_half,
  input  logic          playback,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] total_words,
  output logic          ovr,
  output logic          udr,
  output logic          half_en,
  output logic          half_irq
);

  logic [CW:0] twice_count;
  logic [CW:0] depth_ext;
  logic        level_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr     <= 1'b0;
      udr     <= 1'b0;
      half_en <= 1'b0;
    end else begin
      if (set_ovr)    ovr <= 1'b1;
      else if (st_wr) ovr <= ovr & keep_ovr;
      if (set_udr)    udr <= 1'b1;
      else if (st_wr) udr <= udr & keep_udr;
      if (ctl_wr)     half_en <= ctl_half;
    end
  end

  always_comb begin
    twice_count = {count, 1'b0};
    depth_ext   = {1'b0, total_words};
    level_hit   = playback ? (twice_count <= depth_ext) : (twice_count >= depth_ext);
    half_irq    = half_en & level_hit;
  end

  // R7: flags hold between status writes
  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !st_wr) |=> ovr);
  assert_udr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (udr && !st_wr) |=> udr);
  // R5 / R6: an event always leaves its flag set
  assert_ovr_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_ovr |=> ovr);
  assert_udr_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_udr |=> udr);
  // R9: disabling the request silences it
  assert_request_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_half) |=> !half_irq);

endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo #(
  parameter int unsigned BASE_WORDS = 256,
  parameter int unsigned MAX_CODE   = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_playback,
  input  logic [3:0]  cfg_chan,
  input  logic [2:0]  cfg_size_code,
  input  logic        cpu_wr,
  input  logic [31:0] cpu_wdata,
  input  logic        cpu_rd,
  output logic [23:0] cpu_rdata,
  input  logic        ctl_wr,
  input  logic [31:0] ctl_wdata,
  input  logic        st_wr,
  input  logic [31:0] st_wdata,
  output logic [23:0] status,
  input  logic        ser_req,
  input  logic [23:0] ser_wdata,
  output logic [23:0] ser_rdata,
  output logic        half_irq
);
  import afifo_pkg::*;

  localparam int unsigned RAM_WORDS = BASE_WORDS << MAX_CODE;
  localparam int unsigned AW        = $clog2(RAM_WORDS);
  localparam int unsigned CW        = AW + 1;

  dir_e          dir;
  logic [3:0]    chan_eff;
  logic [CW-1:0] total_words;
  logic [CW-1:0] count;
  logic          push, pop, clr;
  logic [23:0]   push_data, pop_data;
  logic          push_drop, pop_empty;
  logic          ovr, udr, half_en;
  logic [15:0]   frames;
  logic [LVL_W-1:0] lvl_field;
  logic          unused_bits;

  assign dir = cfg_playback ? DIR_PLAYBACK : DIR_CAPTURE;

  afifo_geometry #(.BASE_WORDS(BASE_WORDS), .MAX_CODE(MAX_CODE), .CW(CW)) u_geom (
    .size_code   (cfg_size_code),
    .chan        (cfg_chan),
    .chan_eff    (chan_eff),
    .total_words (total_words)
  );

  always_comb begin
    clr = ctl_wr & ctl_wdata[CTL_CLR_BIT];
    if (dir == DIR_PLAYBACK) begin
      push      = cpu_wr;
      push_data = cpu_wdata[DATA_W-1:0];
      pop       = ser_req;
    end else begin
      push      = ser_req;
      push_data = ser_wdata;
      pop       = cpu_rd;
    end
  end

  afifo_store #(.RAM_WORDS(RAM_WORDS), .AW(AW), .CW(CW)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .push        (push),
    .pop         (pop),
    .wdata       (push_data),
    .total_words (total_words),
    .rdata       (pop_data),
    .count       (count),
    .push_drop   (push_drop),
    .pop_empty   (pop_empty)
  );

  afifo_flags #(.CW(CW)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_ovr     (push_drop),
    .set_udr     (pop_empty),
    .st_wr       (st_wr),
    .keep_ovr    (st_wdata[OVR_BIT]),
    .keep_udr    (st_wdata[UDR_BIT]),
    .ctl_wr      (ctl_wr),
    .ctl_half    (ctl_wdata[CTL_HALF_BIT]),
    .playback    (cfg_playback),
    .count       (count),
    .total_words (total_words),
    .ovr         (ovr),
    .udr         (udr),
    .half_en     (half_en),
    .half_irq    (half_irq)
  );

  assign cpu_rdata = (dir == DIR_CAPTURE)  ? pop_data : '0;
  assign ser_rdata = (dir == DIR_PLAYBACK) ? pop_data : '0;

  always_comb begin
    frames    = frames_of(16'(count), chan_eff);
    lvl_field = frames[LVL_W-1:0];
    status    = '0;
    status[LVL_LSB +: LVL_W] = lvl_field;
    status[OVR_BIT]          = ovr;
    status[UDR_BIT]          = udr;
  end

  assign unused_bits = ^{cpu_wdata[31:24], ctl_wdata[31:21], ctl_wdata[19:1],
                         st_wdata[31:5], st_wdata[3:1], frames, half_en};

  // R2: reported frames never exceed the configured depth
  assert_frames_fit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(status[LVL_LSB +: LVL_W]) * 32'(chan_eff)) <= 32'(total_words));
  // R1: depth always fits in the RAM and is never zero
  assert_depth_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(total_words) <= RAM_WORDS) && (total_words != '0));

endmodule

// File: tb/test_audio_sample_fifo.sv
module test_audio_sample_fifo;

  localparam int BASE = 16;
  localparam int MAXC = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_playback = 1'b1;
  logic [3:0]  cfg_chan = 4'd1;
  logic [2:0]  cfg_size_code = 3'd0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0, ctl_wr = 1'b0, st_wr = 1'b0, ser_req = 1'b0;
  logic [31:0] cpu_wdata = '0, ctl_wdata = '0, st_wdata = '0;
  logic [23:0] ser_wdata = '0;
  logic [23:0] cpu_rdata, ser_rdata, status;
  logic        half_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  audio_sample_fifo #(.BASE_WORDS(BASE), .MAX_CODE(MAXC)) i_audio_sample_fifo (
    .clk(clk), .rst_n(rst_n), .cfg_playback(cfg_playback), .cfg_chan(cfg_chan),
    .cfg_size_code(cfg_size_code), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .st_wr(st_wr), .st_wdata(st_wdata), .status(status), .ser_req(ser_req),
    .ser_wdata(ser_wdata), .ser_rdata(ser_rdata), .half_irq(half_irq)
  );

  function automatic int clampc(input int c);
    if (c < 1) return 1;
    if (c > 8) return 8;
    return c;
  endfunction

  function automatic int exp_total(input int code, input int c);
    int cc, pw, cap;
    cc  = clampc(c);
    cap = BASE * (1 << ((code > MAXC) ? MAXC : code));
    pw  = 1;
    while (pw < cc) pw = pw * 2;
    return (cap / pw) * cc;
  endfunction

  function automatic logic [23:0] word(input int k, input int salt);
    return 24'(k * 70019 + salt * 131 + 24'h5A);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cpu_wr = 0; cpu_rd = 0; ctl_wr = 0; st_wr = 0; ser_req = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int tot, cc, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset status", status, 0);
    chk("R9 reset request off", half_irq, 0);
    chk("reset ser_rdata", ser_rdata, 0);

    // Playback sweep over size codes and channel counts (R1 R2 R3 R5 R6 R7 R9)
    for (int code = 0; code < 3; code++) begin
      for (int ch = 0; ch < 10; ch++) begin
        cfg_playback = 1; cfg_chan = 4'(ch); cfg_size_code = 3'(code);
        ctl_wr = 1; ctl_wdata = 32'h0010_0001; tick();
        tot = exp_total(code, ch); cc = clampc(ch);
        chk("R8 clear empties", status[16:8], 0);
        for (int k = 0; k <= tot; k++) begin
          cpu_wr = 1; cpu_wdata = {8'hC3, word(k, code * 16 + ch)}; tick();
          w = (k < tot) ? k + 1 : tot;
          chk("R9 playback request", half_irq, (2 * w <= tot) ? 1 : 0);
          if (k == tot - 1) chk("R1 not yet full", status[4], 0);
        end
        chk("R1 R5 full at depth", status[4], 1);
        chk("R2 frame level", status[16:8], tot / cc);
        for (int k = 0; k < tot; k++) begin
          ser_req = 1; tick();
          chk("R3 playback order", ser_rdata, word(k, code * 16 + ch));
        end
        ser_req = 1; tick();
        chk("R6 empty pop data", ser_rdata, 0);
        chk("R6 empty pop flag", status[0], 1);
        chk("R6 level stays zero", status[16:8], 0);
        st_wr = 1; st_wdata = 32'h0; tick();
        chk("R7 zero write clears", status[4:0], 0);
      end
    end

    // Capture (R4 R5 R6 R9)
    for (int ch = 2; ch < 4; ch++) begin
      cfg_playback = 0; cfg_chan = 4'(ch); cfg_size_code = 3'd0;
      ctl_wr = 1; ctl_wdata = 32'h0010_0001; tick();
      tot = exp_total(0, ch);
      cpu_wr = 1; cpu_wdata = 32'h00AB_CDEF; tick();
      chk("R4 cpu write ignored in capture", status[16:8], 0);
      for (int k = 0; k <= tot; k++) begin
        ser_req = 1; ser_wdata = word(k, 99 + ch); tick();
        w = (k < tot) ? k + 1 : tot;
        chk("R9 capture request", half_irq, (2 * w >= tot) ? 1 : 0);
      end
      chk("R5 capture lost push", status[4], 1);
      for (int k = 0; k < tot; k++) begin
        cpu_rd = 1; tick();
        chk("R4 capture order", cpu_rdata, word(k, 99 + ch));
      end
      cpu_rd = 1; tick();
      chk("R6 capture empty read", cpu_rdata, 0);
      chk("R6 capture empty flag", status[0], 1);
      // R7: keep bit 4, clear bit 0
      st_wr = 1; st_wdata = 32'h10; tick();
      chk("R7 selective clear", status[4:0], 5'h10);
      st_wr = 1; st_wdata = 32'h0; tick();
    end

    // Same-cycle push and pop (R10), playback, 16 words deep
    cfg_playback = 1; cfg_chan = 4'd1; cfg_size_code = 3'd0;
    ctl_wr = 1; ctl_wdata = 32'h0010_0001; tick();
    cpu_wr = 1; cpu_wdata = 32'h0000_0001; tick();
    cpu_wr = 1; cpu_wdata = 32'h0000_0002; ser_req = 1; tick();
    chk("R10 push+pop level", status[16:8], 1);
    chk("R10 push+pop data", ser_rdata, 1);
    for (int k = 3; k <= 17; k++) begin
      cpu_wr = 1; cpu_wdata = 32'(k); tick();
    end
    chk("R10 full before combo", status[16:8], 16);
    cpu_wr = 1; cpu_wdata = 32'h0000_00EE; ser_req = 1; tick();
    chk("R10 full push dropped", status[4], 1);
    chk("R10 level after combo", status[16:8], 15);
    chk("R10 popped word", ser_rdata, 2);
    for (int k = 3; k <= 17; k++) begin
      ser_req = 1; tick();
      chk("R10 remaining order", ser_rdata, k);
    end

    // Clear with concurrent push; flags unaffected (R8)
    for (int k = 0; k < 3; k++) begin
      cpu_wr = 1; cpu_wdata = 32'(k); tick();
    end
    ctl_wr = 1; ctl_wdata = 32'h0010_0001; cpu_wr = 1; cpu_wdata = 32'h77; tick();
    chk("R8 clear beats push", status[16:8], 0);
    chk("R8 flag kept", status[4], 1);
    // cpu_rd has no effect in playback (R3)
    cpu_wr = 1; cpu_wdata = 32'h55; tick();
    cpu_rd = 1; tick();
    chk("R3 cpu read ignored", status[16:8], 1);
    chk("R3 cpu_rdata quiet", cpu_rdata, 0);
    // Request disabled (R9)
    ctl_wr = 1; ctl_wdata = 32'h0; tick();
    chk("R9 request disabled", half_irq, 0);
    // Event beats same-cycle status clear (R7)
    st_wr = 1; st_wdata = 32'h0; ser_req = 1; tick();
    ser_req = 1; st_wr = 1; st_wdata = 32'h0; tick();
    chk("R7 event wins over write", status[0], 1);

    finish_run();
  end

endmodule